// File: doc/BRIEF.md
# Multichannel Scan Sequencer with Wrapping Result Buffer

The block runs a burst of analog-to-digital conversions over a list of channels. A 2-bit scan-mode field and a selected channel, taken from the configuration registers, pick the list. A start pulse from the bus interface launches the burst. The sequencer issues one conversion request at a time to an external converter and waits for its done strobe. Each returned 8-bit result goes into the next slot of a small result memory. When the last conversion of the burst has finished, the block raises a burst-complete flag, which the bus side uses to release its clock.

The results are then read one byte per request, in the order they were converted. A read past the last stored result wraps to the first result of the same burst. The wrap point is the number of results that burst actually stored, latched when the burst ends, not the memory depth. A new burst clears the old results and moves the read position back to the start. When reference select is active, the channel whose pin doubles as the reference input is left out of the multichannel modes.

Top module: `scan_seq`

## Requirements
- R1: Scan mode 2'b00 converts channels 0, 1, … up to the selected channel, in ascending order.
- R2: Scan mode 2'b01 converts the selected channel REPEAT_N times (8 by default).
- R3: Scan mode 2'b10 converts channels HIGH_BASE (6 by default) up to the selected channel, in ascending order. If the selected channel is below HIGH_BASE, it converts only the selected channel, once.
- R4: Scan mode 2'b11 converts the selected channel once.
- R5: With reference select at 1, channel REF_CH (11 by default) is skipped in the stepping scans of R1 and R3. The modes of R2 and R4 are not affected.
- R6: Only one conversion is in flight at a time. `conv_start` is a one-cycle pulse, and the next pulse comes in the cycle right after the `conv_done` that completed the previous conversion. Each result is stored in the next memory slot, and nothing is converted after the list is exhausted.
- R7: `busy` is high from the cycle after an accepted start until the end of the burst. `burst_done` goes low on an accepted start and rises in the cycle after the `conv_done` of the last conversion, never earlier.
- R8: With `burst_done` high, each `rd_req` returns one stored result on `rd_data`, with `rd_valid` high in the following cycle. Results come back in conversion order, starting at the first result of the burst.
- R9: After the last stored result of the burst has been read, the next read returns the first result again. The wrap uses the stored count.
- R10: An accepted start resets the read position, so reads after a new burst return only that burst's results, starting with its first. A start while `busy` is high is ignored.
- R11: `rd_req` is ignored (no `rd_valid`) while no completed burst is held, while a burst is running, and in the same cycle as a `start` accepted while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Burst start pulse from the bus interface |
| cfg_scan | input | 2 | Scan mode: 00 low-up, 01 repeat, 10 high-up, 11 single |
| cfg_sel | input | CW=$clog2(NUM_CH) | Selected channel; values above NUM_CH-1 act as NUM_CH-1 |
| cfg_ref | input | 1 | Reference select; 1 drops channel REF_CH from stepping scans |
| conv_start | output | 1 | One-cycle conversion request |
| conv_ch | output | CW | Channel for the current conversion |
| conv_done | input | 1 | Converter finished; conv_data valid |
| conv_data | input | DW (8) | Conversion result |
| busy | output | 1 | Burst in progress |
| burst_done | output | 1 | All conversions of the latest burst finished |
| rd_req | input | 1 | Read one result byte |
| rd_data | output | DW (8) | Result byte returned by a read |
| rd_valid | output | 1 | rd_data valid (cycle after an accepted read) |

## Verification
Two functions can meet in one cycle: a result read and the start of a new burst. They collide when `rd_req` and `start` are raised on the same edge after a completed burst. The bench does this on purpose and expects no `rd_valid` in the next cycle. It also expects the first read after the new burst to return that burst's first result, which shows the start won and reset the read position. A start and a read are also driven into a running burst, and the bench checks that neither the channel sequence nor the read output changes.

// File: rtl/scan_pkg.sv
// Package: shared types for the scan sequencer.
// Assumes: the scan-mode encoding below is the one the configuration registers supply.
package scan_pkg;

    typedef enum logic [1:0] {
        SCAN_LOW_UP  = 2'b00,
        SCAN_REPEAT  = 2'b01,
        SCAN_HIGH_UP = 2'b10,
        SCAN_SINGLE  = 2'b11
    } scan_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ISSUE = 2'b01,
        ST_WAIT  = 2'b10
    } seq_state_e;

endpackage

// File: rtl/scan_list.sv
// scan_list: combinational channel-list generator.
// Gives the first channel of a burst and the channel after the current one
// for the stepping modes, skipping the shared reference channel when asked.
// Assumes: cur_ch is a channel this generator produced for the same settings.
module scan_list
    import scan_pkg::*;
#(
    parameter int NUM_CH    = 12,
    parameter int REF_CH    = 11,
    parameter int HIGH_BASE = 6,
    parameter int CW        = $clog2(NUM_CH)
) (
    input  scan_mode_e      mode,
    input  logic [CW-1:0]   sel,
    input  logic            ref_en,
    input  logic [CW-1:0]   cur_ch,
    output logic [CW-1:0]   first_ch,
    output logic            first_ok,
    output logic [CW-1:0]   next_ch,
    output logic            next_ok,
    output logic            stepping
);

    // Work out the list start and the next step from the current channel.
    always_comb begin : gen_list
        int s;
        int b;
        int f;
        int n;
        s = (int'(sel) > NUM_CH - 1) ? NUM_CH - 1 : int'(sel);
        stepping = (mode == SCAN_LOW_UP) || ((mode == SCAN_HIGH_UP) && (s >= HIGH_BASE));
        if (mode == SCAN_LOW_UP)
            b = 0;
        else if (stepping)
            b = HIGH_BASE;
        else
            b = s;
        f = b;
        if (stepping && ref_en && (f == REF_CH))
            f = f + 1;
        first_ok = (f <= s);
        first_ch = CW'(f);
        n = int'(cur_ch) + 1;
        if (ref_en && (n == REF_CH))
            n = n + 1;
        next_ok = stepping && (n <= s);
        next_ch = CW'(n);
    end

endmodule

// File: rtl/scan_ctrl.sv
// scan_ctrl: burst state machine.
// Latches the settings on an accepted start, issues one conversion at a time,
// counts repeats and flags burst completion after the last done strobe.
// Assumes: conv_done is only meaningful while a conversion is outstanding.
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int REF_CH   = 11,
    parameter int REPEAT_N = 8,
    parameter int CW       = 4,
    parameter int NW       = $clog2(REPEAT_N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  scan_mode_e      cfg_mode,
    input  logic [CW-1:0]   cfg_sel,
    input  logic            cfg_ref,
    input  logic            conv_done,
    input  logic [CW-1:0]   lst_first_ch,
    input  logic            lst_first_ok,
    input  logic [CW-1:0]   lst_next_ch,
    input  logic            lst_next_ok,
    input  logic            lst_stepping,
    output scan_mode_e      lst_mode,
    output logic [CW-1:0]   lst_sel,
    output logic            lst_ref,
    output logic [CW-1:0]   cur_ch,
    output logic            conv_start,
    output logic            wr_en,
    output logic            buf_clr,
    output logic            buf_fin,
    output logic            busy,
    output logic            burst_done
);

    seq_state_e    state_q;
    scan_mode_e    mode_q;
    logic [CW-1:0] sel_q;
    logic          ref_q;
    logic [CW-1:0] cur_q;
    logic [NW-1:0] cnt_q;
    logic          done_q;
    logic          start_acc;
    logic          more;

    // Decode the accepted start and whether another conversion follows.
    always_comb begin
        start_acc = start && (state_q == ST_IDLE);
        if (mode_q == SCAN_REPEAT)
            more = (int'(cnt_q) + 1) < REPEAT_N;
        else
            more = lst_next_ok;
    end

    // Feed the list generator live settings when idle, latched ones otherwise.
    always_comb begin
        lst_mode = (state_q == ST_IDLE) ? cfg_mode : mode_q;
        lst_sel  = (state_q == ST_IDLE) ? cfg_sel  : sel_q;
        lst_ref  = (state_q == ST_IDLE) ? cfg_ref  : ref_q;
    end

    // Buffer and converter strobes derived from the state.
    always_comb begin
        conv_start = (state_q == ST_ISSUE);
        wr_en      = (state_q == ST_WAIT) && conv_done;
        buf_clr    = start_acc;
        buf_fin    = (wr_en && !more) || (start_acc && !lst_first_ok);
        busy       = (state_q != ST_IDLE);
        cur_ch     = cur_q;
        burst_done = done_q;
    end

    // Burst sequencing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= SCAN_LOW_UP;
            sel_q   <= '0;
            ref_q   <= 1'b0;
            cur_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_acc) begin
                        mode_q <= cfg_mode;
                        sel_q  <= cfg_sel;
                        ref_q  <= cfg_ref;
                        cnt_q  <= '0;
                        cur_q  <= lst_first_ch;
                        if (lst_first_ok) begin
                            done_q  <= 1'b0;
                            state_q <= ST_ISSUE;
                        end else begin
                            done_q  <= 1'b1;
                        end
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (conv_done) begin
                        cnt_q <= cnt_q + NW'(1);
                        if (more) begin
                            if (mode_q != SCAN_REPEAT)
                                cur_q <= lst_next_ch;
                            state_q <= ST_ISSUE;
                        end else begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5
    ref_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && ref_q && lst_stepping) |-> (cur_q != CW'(REF_CH)));

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R7
    done_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(conv_done) || $past(start)));

    // R7
    busy_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !burst_done);

endmodule

// File: rtl/scan_buf.sv
// scan_buf: result memory with a wrapping read pointer.
// Stores results in arrival order, latches the stored count at burst end and
// returns bytes one per read, wrapping at that count.
// Assumes: clr and wr_en never coincide; no more than DEPTH writes per burst.
module scan_buf #(
    parameter int DEPTH = 12,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          fin,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    logic [DW-1:0]   mem [DEPTH];
    logic [CNTW-1:0] wr_idx;
    logic [CNTW-1:0] count_q;
    logic [AW-1:0]   rd_ptr;
    logic            rd_go;

    assign rd_go = rd_en && (count_q != '0) && !clr;

    // Result storage.
    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_idx) < DEPTH))
            mem[wr_idx[AW-1:0]] <= wr_data;
    end

    // Write index, stored count and read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx  <= '0;
            count_q <= '0;
            rd_ptr  <= '0;
        end else if (clr) begin
            wr_idx  <= '0;
            count_q <= '0;
            rd_ptr  <= '0;
        end else begin
            if (wr_en)
                wr_idx <= wr_idx + CNTW'(1);
            if (fin)
                count_q <= wr_idx + CNTW'(wr_en);
            if (rd_go) begin
                if ((int'(rd_ptr) + 1) >= int'(count_q))
                    rd_ptr <= '0;
                else
                    rd_ptr <= rd_ptr + AW'(1);
            end
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go)
                rd_data <= mem[rd_ptr];
        end
    end

    // R6
    wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < DEPTH));

    // R9
    rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q != '0) |-> (int'(rd_ptr) < int'(count_q)));

endmodule

// File: rtl/scan_seq.sv
// scan_seq: top of the scan sequencer.
// Joins the channel-list generator, the burst controller and the result buffer.
// Assumes: the converter answers every conv_start with exactly one conv_done.
module scan_seq
    import scan_pkg::*;
#(
    parameter int NUM_CH    = 12,
    parameter int DEPTH     = 12,
    parameter int DW        = 8,
    parameter int REF_CH    = NUM_CH - 1,
    parameter int HIGH_BASE = NUM_CH / 2,
    parameter int REPEAT_N  = 8,
    parameter int CW        = $clog2(NUM_CH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    cfg_scan,
    input  logic [CW-1:0] cfg_sel,
    input  logic          cfg_ref,
    output logic          conv_start,
    output logic [CW-1:0] conv_ch,
    input  logic          conv_done,
    input  logic [DW-1:0] conv_data,
    output logic          busy,
    output logic          burst_done,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    scan_mode_e    lst_mode;
    logic [CW-1:0] lst_sel;
    logic          lst_ref;
    logic [CW-1:0] first_ch;
    logic          first_ok;
    logic [CW-1:0] next_ch;
    logic          next_ok;
    logic          stepping;
    logic          wr_en;
    logic          buf_clr;
    logic          buf_fin;
    logic          rd_en;

    scan_list #(
        .NUM_CH(NUM_CH), .REF_CH(REF_CH), .HIGH_BASE(HIGH_BASE), .CW(CW)
    ) u_list (
        .mode(lst_mode), .sel(lst_sel), .ref_en(lst_ref), .cur_ch(conv_ch),
        .first_ch(first_ch), .first_ok(first_ok),
        .next_ch(next_ch), .next_ok(next_ok), .stepping(stepping)
    );

    scan_ctrl #(
        .REF_CH(REF_CH), .REPEAT_N(REPEAT_N), .CW(CW)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_mode(scan_mode_e'(cfg_scan)), .cfg_sel(cfg_sel), .cfg_ref(cfg_ref),
        .conv_done(conv_done),
        .lst_first_ch(first_ch), .lst_first_ok(first_ok),
        .lst_next_ch(next_ch), .lst_next_ok(next_ok), .lst_stepping(stepping),
        .lst_mode(lst_mode), .lst_sel(lst_sel), .lst_ref(lst_ref),
        .cur_ch(conv_ch), .conv_start(conv_start), .wr_en(wr_en),
        .buf_clr(buf_clr), .buf_fin(buf_fin), .busy(busy), .burst_done(burst_done)
    );

    // A read is served only with a finished burst held and no start this cycle.
    assign rd_en = rd_req && burst_done && !start;

    scan_buf #(
        .DEPTH(DEPTH), .DW(DW)
    ) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(wr_en), .wr_data(conv_data),
        .fin(buf_fin), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // R11
    rd_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> burst_done);

endmodule

// File: tb/scan_seq_bench.sv
module scan_seq_bench;

    localparam int REF_CH    = 11;
    localparam int HIGH_BASE = 6;
    localparam int REPEAT_N  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] cfg_scan = 2'b00;
    logic [3:0] cfg_sel = 4'd0;
    logic       cfg_ref = 1'b0;
    logic       conv_done = 1'b0;
    logic [7:0] conv_data = 8'd0;
    logic       rd_req = 1'b0;
    logic       conv_start;
    logic [3:0] conv_ch;
    logic       busy;
    logic       burst_done;
    logic [7:0] rd_data;
    logic       rd_valid;

    int checks = 0;
    int fails  = 0;
    int exp_ch [16];
    int exp_n;
    int rec [16];
    bit finished = 1'b0;

    always #10 clk = ~clk;

    scan_seq u_scan_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_scan(cfg_scan),
        .cfg_sel(cfg_sel), .cfg_ref(cfg_ref), .conv_start(conv_start),
        .conv_ch(conv_ch), .conv_done(conv_done), .conv_data(conv_data),
        .busy(busy), .burst_done(burst_done), .rd_req(rd_req),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Expected channel list from the mode rules.
    task automatic build_exp(input int mode, input int sel, input bit rf);
        exp_n = 0;
        case (mode)
            0: for (int c = 0; c <= sel; c++)
                   if (!(rf && c == REF_CH)) begin exp_ch[exp_n] = c; exp_n++; end
            1: for (int k = 0; k < REPEAT_N; k++) begin exp_ch[exp_n] = sel; exp_n++; end
            2: if (sel >= HIGH_BASE) begin
                   for (int c = HIGH_BASE; c <= sel; c++)
                       if (!(rf && c == REF_CH)) begin exp_ch[exp_n] = c; exp_n++; end
               end else begin
                   exp_ch[0] = sel; exp_n = 1;
               end
            default: begin exp_ch[0] = sel; exp_n = 1; end
        endcase
    endtask

    function automatic string mode_tag(input int mode, input bit rf);
        if (rf && (mode == 0 || mode == 2)) return "R5";
        case (mode)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic run_burst(input int mode, input int sel, input bit rf,
                             input bit rd_on_start, input bit disturb);
        string tg;
        build_exp(mode, sel, rf);
        tg = mode_tag(mode, rf);
        @(negedge clk);
        cfg_scan = 2'(mode); cfg_sel = 4'(sel); cfg_ref = rf;
        start = 1'b1; rd_req = rd_on_start;
        @(negedge clk);
        start = 1'b0; rd_req = 1'b0;
        if (rd_on_start) check(rd_valid == 1'b0, "R11 read on start", int'(rd_valid), 0);
        check(busy == 1'b1, "R7 busy", int'(busy), 1);
        check(burst_done == 1'b0, "R7 done cleared", int'(burst_done), 0);
        for (int i = 0; i < exp_n; i++) begin
            int t = 0;
            while (!conv_start && t < 20) begin @(negedge clk); t++; end
            check(conv_start == 1'b1, "R6 request seen", int'(conv_start), 1);
            check(int'(conv_ch) == exp_ch[i], tg, int'(conv_ch), exp_ch[i]);
            check(burst_done == 1'b0, "R7 early done", int'(burst_done), 0);
            @(negedge clk);
            if (disturb && i == 0) begin
                cfg_scan = ~2'(mode); cfg_sel = 4'd2; start = 1'b1; rd_req = 1'b1;
                @(negedge clk);
                start = 1'b0; rd_req = 1'b0;
                check(rd_valid == 1'b0, "R11 read while busy", int'(rd_valid), 0);
            end
            repeat ($urandom % 3) @(negedge clk);
            rec[i] = int'($urandom % 256);
            conv_data = 8'(rec[i]); conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
            if (i == exp_n - 1) begin
                check(burst_done == 1'b1, "R7 done after last", int'(burst_done), 1);
                check(busy == 1'b0, "R7 busy end", int'(busy), 0);
            end else begin
                check(conv_start == 1'b1, "R6 next request", int'(conv_start), 1);
            end
        end
        repeat (3) @(negedge clk);
        check(conv_start == 1'b0, "R6 no extra request", int'(conv_start), 0);
    endtask

    task automatic read_results(input int nrd);
        for (int k = 0; k < nrd; k++) begin
            @(negedge clk);
            rd_req = 1'b1;
            @(negedge clk);
            rd_req = 1'b0;
            check(rd_valid == 1'b1, "R8 read valid", int'(rd_valid), 1);
            check(int'(rd_data) == rec[k % exp_n], (k < exp_n) ? "R8 order" : "R9 wrap",
                  int'(rd_data), rec[k % exp_n]);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R7 reset busy", int'(busy), 0);
        check(burst_done == 1'b0, "R7 reset done", int'(burst_done), 0);
        check(conv_start == 1'b0, "R6 reset request", int'(conv_start), 0);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(rd_valid == 1'b0, "R11 read before burst", int'(rd_valid), 0);

        run_burst(0, 11, 1'b0, 1'b0, 1'b0); read_results(14);
        run_burst(0, 11, 1'b1, 1'b0, 1'b0); read_results(13);
        run_burst(2, 11, 1'b1, 1'b0, 1'b0); read_results(7);
        run_burst(2, 3, 1'b0, 1'b0, 1'b0);  read_results(2);
        run_burst(1, 11, 1'b1, 1'b0, 1'b0); read_results(9);
        run_burst(3, 11, 1'b1, 1'b0, 1'b0); read_results(2);
        run_burst(0, 0, 1'b0, 1'b0, 1'b0);  read_results(2);
        // R10: start ignored mid-burst, new burst restarts the read position
        run_burst(0, 5, 1'b0, 1'b0, 1'b1);  read_results(3);
        run_burst(2, 9, 1'b0, 1'b0, 1'b0);  read_results(5);
        // R11: read and start collide after a finished burst
        run_burst(1, 4, 1'b0, 1'b1, 1'b0);  read_results(10);

        for (int b = 0; b < 20; b++) begin
            int m = int'($urandom % 4);
            int s = int'($urandom % 12);
            bit r = bit'($urandom % 2);
            run_burst(m, s, r, bit'($urandom % 2), 1'b0);
            read_results(int'($urandom % (exp_n + 4)) + 1);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule